// File: doc/BRIEF.md
# Byte Stream Keyed Encryptor

This block encrypts a stream of bytes one byte at a time. A single 8-bit input bus carries both the key and the plaintext. Three strobe lines steer it. A clear strobe wipes the stored key, the byte counter and the output. A key strobe captures the byte on the bus as the key. A data strobe encrypts the byte on the bus and places the ciphertext on the output. The strobes are treated as asynchronous. Each one passes through a synchroniser and then an edge detector, so that only a rising edge acts.

The block has two cipher modes, chosen by a static mode input. In base mode each byte is XORed with the key. In pattern mode each byte is XORed with the key rotated left by the byte's position, counted modulo 8 from the last key load or clear. Until a key has been loaded, data passes through unchanged. The output is registered and holds its value until the next data or clear edge.

Top module: `byte_stream_encryptor`

## Requirements
- R1: A rising edge on `clr_strobe` sets `dout` to 0x00, forgets the key and resets the byte counter to 0, so that the next data byte passes through unchanged.
- R2: While no key is loaded, a data edge copies `din` to `dout` unchanged.
- R3: A rising edge on `key_strobe` stores `din` as the key. Later changes on `din` do not alter the stored key, and a key edge on its own leaves `dout` unchanged.
- R4: With `pattern_en` = 0 and a key loaded, a data edge sets `dout` = `din` XOR key.
- R5: With `pattern_en` = 1 and a key loaded, a data edge sets `dout` = `din` XOR (key rotated left by n), where n is the count of earlier data edges since the last key load or clear, taken modulo 8. The count advances on every data edge in either mode.
- R6: Each key load resets the byte counter to 0.
- R7: A strobe raised just before a clock edge takes effect on `dout` at the third rising clock edge: two synchroniser stages, then one output register. Between events `dout` holds its value.
- R8: Only a rising edge on a strobe acts. A strobe held high for many cycles counts as one event, and its falling edge does nothing.
- R9: If a key edge and a data edge are detected in the same cycle, the data byte is encrypted with the previous key and counter. The new key then takes effect, with the counter at 0.
- R10: If a clear edge is detected in the same cycle as a key or data edge, the clear wins: `dout` becomes 0x00 and no key remains loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_strobe | input | 1 | Asynchronous clear strobe; acts on its rising edge |
| key_strobe | input | 1 | Asynchronous key-load strobe; acts on its rising edge |
| data_strobe | input | 1 | Asynchronous data strobe; acts on its rising edge |
| pattern_en | input | 1 | 0 selects base XOR, 1 selects the rotating key pattern |
| din | input | 8 | Shared key and plaintext bus |
| dout | output | 8 | Registered ciphertext byte |

## Verification
The key load and the data encryption can fall in the same cycle, because they share the input bus and their strobes are synchronised separately. The bench raises both strobes on the same clock edge. It checks that the ciphertext uses the old key and counter, and that the following byte uses the new key at position 0. The bench also raises the clear strobe together with data and key strobes, and it expects a zero output followed by a pass-through byte.

// File: rtl/bse_pkg.sv
package bse_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic clr;
    logic key;
    logic data;
  } bse_evt_t;

  // Rotate a key byte left by the given count; pat=0 returns it unchanged.
  function automatic logic [BYTE_W-1:0] key_stream(
    input logic [BYTE_W-1:0] k,
    input logic [IDX_W-1:0]  n,
    input logic              pat
  );
    logic [BYTE_W-1:0] r;
    int sh;
    sh = int'(n);
    if (!pat || sh == 0) r = k;
    else r = (k << sh) | (k >> (BYTE_W - sh));
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] cipher_byte(
    input logic [BYTE_W-1:0] d,
    input logic [BYTE_W-1:0] k,
    input logic [IDX_W-1:0]  n,
    input logic              pat,
    input logic              have_key
  );
    return have_key ? (d ^ key_stream(k, n, pat)) : d;
  endfunction
endpackage

// File: rtl/bse_strobe_sync.sv
module bse_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R8: a detected edge lasts exactly one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bse_key_state.sv
module bse_key_state
  import bse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bse_evt_t          evt,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] key_q,
  output logic              key_ok,
  output logic [IDX_W-1:0]  idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      key_ok <= 1'b0;
      idx_q  <= '0;
    end else if (evt.clr) begin
      key_q  <= '0;
      key_ok <= 1'b0;
      idx_q  <= '0;
    end else if (evt.key) begin
      key_q  <= din;
      key_ok <= 1'b1;
      idx_q  <= '0;
    end else if (evt.data) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt.clr |=> (!key_ok && idx_q == '0));

  p_key_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.key && !evt.clr) |=> (key_ok && key_q == $past(din)));

  p_idx_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.key && !evt.clr) |=> idx_q == '0);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.data && !evt.key && !evt.clr) |=> idx_q == $past(idx_q) + 1'b1);

  p_key_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.key && !evt.clr) |=> $stable(key_q));
endmodule

// File: rtl/bse_cipher_out.sv
module bse_cipher_out
  import bse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bse_evt_t          evt,
  input  logic [BYTE_W-1:0] din,
  input  logic [BYTE_W-1:0] key_q,
  input  logic              key_ok,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic              pattern_en,
  output logic [BYTE_W-1:0] dout
);
  logic [BYTE_W-1:0] next_byte;

  assign next_byte = cipher_byte(din, key_q, idx_q, pattern_en, key_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dout <= '0;
    else if (evt.clr)   dout <= '0;
    else if (evt.data)  dout <= next_byte;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.data && !evt.clr) |=> $stable(dout));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.data && !evt.clr && !key_ok) |=> dout == $past(din));

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt.clr |=> dout == '0);

  p_base_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.data && !evt.clr && key_ok && !pattern_en) |=> (dout ^ $past(din)) == $past(key_q));
endmodule

// File: rtl/byte_stream_encryptor.sv
module byte_stream_encryptor
  import bse_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_strobe,
  input  logic              key_strobe,
  input  logic              data_strobe,
  input  logic              pattern_en,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  localparam int N_STROBES = 3;

  logic [N_STROBES-1:0] strobe_raw;
  logic [N_STROBES-1:0] strobe_rise;
  bse_evt_t             evt;
  logic [BYTE_W-1:0]    key_q;
  logic                 key_ok;
  logic [IDX_W-1:0]     idx_q;

  assign strobe_raw = {clr_strobe, key_strobe, data_strobe};

  for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
    bse_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (strobe_raw[g]),
      .rise     (strobe_rise[g])
    );
  end

  assign evt = bse_evt_t'(strobe_rise);

  bse_key_state state_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .din    (din),
    .key_q  (key_q),
    .key_ok (key_ok),
    .idx_q  (idx_q)
  );

  bse_cipher_out out_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .din        (din),
    .key_q      (key_q),
    .key_ok     (key_ok),
    .idx_q      (idx_q),
    .pattern_en (pattern_en),
    .dout       (dout)
  );

  // R9: coincident key and data edges use the old key for the byte
  p_coincide_old_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.key && evt.data && !evt.clr && key_ok) |=>
      dout == ($past(din) ^ key_stream($past(key_q), $past(idx_q), $past(pattern_en))));
endmodule

// File: tb/byte_stream_encryptor_tb_top.sv
module byte_stream_encryptor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_s = 1'b0, key_s = 1'b0, dat_s = 1'b0, pat = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;

  logic [7:0] m_key = 8'h00;
  logic       m_has = 1'b0;
  int         m_pos = 0;
  logic [7:0] m_out = 8'h00;

  always #4 clk = ~clk;

  byte_stream_encryptor dut_i (
    .clk(clk), .rst_n(rst_n), .clr_strobe(clr_s), .key_strobe(key_s),
    .data_strobe(dat_s), .pattern_en(pat), .din(din), .dout(dout)
  );

  function automatic logic [7:0] ref_rot(input logic [7:0] k, input int n);
    logic [15:0] dbl;
    dbl = {k, k};
    return dbl[15 - (n % 8) -: 8];
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the driver signals a settled result
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) check(dout, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic model(input bit c, input bit k, input bit d, input logic [7:0] v);
    if (c) begin
      m_out = 8'h00; m_has = 1'b0; m_pos = 0; m_key = 8'h00;
    end else begin
      if (d) begin
        m_out = m_has ? (v ^ (pat ? ref_rot(m_key, m_pos) : m_key)) : v;
        m_pos = (m_pos + 1) % 8;
      end
      if (k) begin
        m_key = v; m_has = 1'b1; m_pos = 0;
      end
    end
  endtask

  task automatic strobe(input bit c, input bit k, input bit d, input logic [7:0] v,
                        input int width, input string tag);
    @(negedge clk);
    din = v;
    clr_s = c; key_s = k; dat_s = d;
    repeat (width) @(negedge clk);
    clr_s = 1'b0; key_s = 1'b0; dat_s = 1'b0;
    repeat (4) @(negedge clk);
    model(c, k, d, v);
    exp_q.push_back(m_out);
    tag_q.push_back(tag);
    ->chk_ev;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: dout=%02h expected=done", dout);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout, 8'h00, "R1 reset value");

    // R2 pass-through before any key
    strobe(0, 0, 1, 8'h5A, 1, "R2 passthrough");
    // R3 key load alone leaves dout
    strobe(0, 1, 0, 8'hC3, 1, "R3 key load holds dout");
    din = 8'hFF; // bus changes must not disturb the key
    // R4 base XOR
    strobe(0, 0, 1, 8'h12, 1, "R4 base xor");
    strobe(0, 0, 1, 8'hA0, 1, "R4 base xor 2");

    // R7 latency: change at third clock edge after the strobe
    @(negedge clk);
    din = 8'h0F; dat_s = 1'b1;
    @(negedge clk); @(negedge clk);
    check(dout, m_out, "R7 not yet at second edge");
    @(negedge clk);
    model(0, 0, 1, 8'h0F);
    check(dout, m_out, "R7 updated at third edge");
    dat_s = 1'b0;
    repeat (4) @(negedge clk);
    check(dout, m_out, "R7 holds after strobe falls");

    // R5/R6 pattern mode across the wrap
    pat = 1'b1;
    strobe(0, 1, 0, 8'h81, 1, "R6 key reload");
    for (int i = 0; i < 10; i++)
      strobe(0, 0, 1, 8'(8'h11 * i), 1, "R5 pattern byte");
    strobe(0, 1, 0, 8'h3C, 1, "R6 new key");
    strobe(0, 0, 1, 8'h00, 1, "R6 index back to 0");

    // R8 held-high strobe acts once
    strobe(0, 0, 1, 8'h77, 20, "R8 long strobe one byte");
    strobe(0, 0, 1, 8'h77, 1, "R8 next index after long strobe");

    // R9 coincident key and data
    strobe(0, 1, 1, 8'h96, 1, "R9 old key used");
    strobe(0, 0, 1, 8'h01, 1, "R9 new key at index 0");
    pat = 1'b0;
    strobe(0, 1, 1, 8'h44, 1, "R9 base mode coincide");

    // R10 clear wins, R1 clear empties
    strobe(1, 0, 1, 8'hEE, 1, "R10 clear with data");
    strobe(0, 0, 1, 8'h3B, 1, "R1 passthrough after clear");
    strobe(0, 1, 0, 8'h55, 1, "R3 key after clear");
    strobe(1, 1, 0, 8'h66, 1, "R10 clear with key");
    strobe(0, 0, 1, 8'h29, 1, "R10 no key after clear+key");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule